// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element Cluster

This block is a square grid of bit-serial processing elements that all obey one instruction per cycle, broadcast by an outside controller. Each element holds four one-bit registers (carry, work, flag and activity), a private bit-addressed memory and a one-bit ALU whose widest operation is a full add with carry. Elements trade bits with their four nearest neighbours in lock step. An element whose activity bit is clear sits out every instruction except the one that rewrites the activity bit.

The controller moves data in and out through an edge register. In one cycle it either captures the work bits of a whole row or a whole column, or deposits a word into them. A responder counter gives the number of elements whose flag bit is set, for associative searches. An instruction tagged as making two memory references takes two cycles, and the block raises `busy` during the second one.

Top module: `bsimd_cluster`

## Requirements
- R1: With `ins_two`=0, an instruction presented with `ins_valid`=1 takes effect at that clock edge. Opcodes: 0 no-op, 1 load register `dst` from memory bit `ins_addr`, 2 store register `src` to memory bit `ins_addr`, 3 copy, 4 AND, 5 OR, 6 XOR (for 4 to 6, `dst` = `dst` op `src`), 7 `dst` = NOT `src`, 15 clear carry. Register selects: 0 carry, 1 work, 2 flag, 3 activity.
- R2: Opcode 8 adds memory bit, register `src` and carry: the carry-out goes to the carry register and the sum goes to `dst` (the sum wins when `dst` is 0). Opcode 9 does the same add but writes the sum back to the memory bit.
- R3: An instruction with `ins_two`=1 presented while `busy`=0 raises `busy` for exactly the next cycle and takes effect at the edge that ends that cycle. Inputs presented while `busy`=1 are ignored.
- R4: Opcodes 10, 11, 12, 13 write `dst` with the `src` register of the west, east, south and north neighbour respectively, so data moves east, west, north and south. Row 0 is the north edge and column 0 the west edge. A missing neighbour supplies 0.
- R5: An element whose activity register is 0 leaves its registers and memory unchanged for every opcode except 14, which sets the activity register from `src` in every element.
- R6: `edge_cmd`=1 captures the work registers of row `edge_idx` (`edge_axis`=0, bit i from column i) or column `edge_idx` (`edge_axis`=1, bit i from row i) into `edge_q` at the edge; `edge_q` holds its value under any other command.
- R7: `edge_cmd`=2 writes `edge_wdata` into the work registers of the selected row or column with the same bit order, regardless of activity, and takes priority over an instruction writing those work registers in the same cycle. `edge_cmd` 0 and 3 do nothing.
- R8: `resp_count` equals the number of elements whose flag register is 1, updated in the cycle after the register changes.
- R9: Synchronous reset clears every carry, work and flag register and all memory, sets every activity register to 1, and clears `busy` and `edge_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Broadcast instruction present |
| ins_op | input | 4 | Opcode |
| ins_src | input | 2 | Source register select |
| ins_dst | input | 2 | Destination register select |
| ins_addr | input | AW | Memory bit address |
| ins_two | input | 1 | Instruction makes two memory references |
| edge_cmd | input | 2 | 0 idle, 1 capture, 2 deposit, 3 idle |
| edge_axis | input | 1 | 0 row, 1 column |
| edge_idx | input | IW | Row or column index |
| edge_wdata | input | N | Deposit data |
| busy | output | 1 | Second cycle of a two-reference instruction |
| edge_q | output | N | Edge register |
| resp_count | output | CW | Number of elements with flag set |

## Verification
A diagonal pattern deposited row by row and captured by column separates row from column addressing and bit order at the edge. The same diagonal shifted in each direction distinguishes the four neighbour links and shows zeros entering at the boundary. Partial masks after an activity load separate masked from active elements, and an add with overlapping ones shows sum and carry landing in the right places, while an instruction slipped in during the busy cycle must leave no trace. A long mix of random instructions and edge commands is compared every cycle with a behavioural model of the grid.

// File: rtl/bsimd_pkg.sv
package bsimd_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDM   = 4'd1,
        OP_STM   = 4'd2,
        OP_MOV   = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_NOT   = 4'd7,
        OP_ADDM  = 4'd8,
        OP_ADDMM = 4'd9,
        OP_SHE   = 4'd10,
        OP_SHW   = 4'd11,
        OP_SHN   = 4'd12,
        OP_SHS   = 4'd13,
        OP_ACT   = 4'd14,
        OP_CLRC  = 4'd15
    } pe_op_e;

    typedef enum logic [1:0] {
        EDGE_IDLE    = 2'd0,
        EDGE_CAPTURE = 2'd1,
        EDGE_DEPOSIT = 2'd2,
        EDGE_SPARE   = 2'd3
    } edge_cmd_e;

    localparam int REG_CARRY = 0;
    localparam int REG_WORK  = 1;
    localparam int REG_FLAG  = 2;
    localparam int REG_ACT   = 3;

    typedef struct packed {
        logic       fire;
        pe_op_e     op;
        logic [1:0] src;
        logic [1:0] dst;
    } pe_ctl_t;

    // returns {carry, sum}
    function automatic logic [1:0] full_add(input logic a, input logic b, input logic ci);
        return {(a & b) | (a & ci) | (b & ci), a ^ b ^ ci};
    endfunction

endpackage

// File: rtl/bsimd_issue.sv
module bsimd_issue
    import bsimd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins_valid,
    input  pe_op_e        ins_op,
    input  logic [1:0]    ins_src,
    input  logic [1:0]    ins_dst,
    input  logic [AW-1:0] ins_addr,
    input  logic          ins_two,
    output pe_ctl_t       ctl,
    output logic [AW-1:0] ctl_addr,
    output logic          busy
);

    logic          busy_q;
    pe_ctl_t       pend_ctl;
    logic [AW-1:0] pend_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pend_ctl  <= '0;
            pend_addr <= '0;
        end else if (busy_q) begin
            busy_q <= 1'b0;
        end else if (ins_valid && ins_two) begin
            busy_q    <= 1'b1;
            pend_ctl  <= '{fire: 1'b1, op: ins_op, src: ins_src, dst: ins_dst};
            pend_addr <= ins_addr;
        end
    end

    always_comb begin
        if (busy_q) begin
            ctl      = pend_ctl;
            ctl_addr = pend_addr;
        end else begin
            ctl      = '{fire: ins_valid & ~ins_two, op: ins_op, src: ins_src, dst: ins_dst};
            ctl_addr = ins_addr;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/bsimd_pe.sv
module bsimd_pe
    import bsimd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  pe_ctl_t       ctl,
    input  logic [AW-1:0] addr,
    input  logic          from_n,
    input  logic          from_s,
    input  logic          from_e,
    input  logic          from_w,
    input  logic          dep_en,
    input  logic          dep_bit,
    output logic          sel_bit,
    output logic          work_bit,
    output logic          flag_bit
);

    logic [3:0]       rq, rn;
    logic [DEPTH-1:0] mq;
    logic             mwe, mwd, mbit, sbit;
    logic [1:0]       fa;

    assign mbit = mq[addr];
    assign sbit = rq[ctl.src];
    assign fa   = full_add(mbit, sbit, rq[REG_CARRY]);

    always_comb begin
        rn  = rq;
        mwe = 1'b0;
        mwd = 1'b0;
        if (ctl.fire) begin
            if (ctl.op == OP_ACT) begin
                rn[REG_ACT] = sbit;
            end else if (rq[REG_ACT]) begin
                case (ctl.op)
                    OP_LDM:  rn[ctl.dst] = mbit;
                    OP_STM:  begin mwe = 1'b1; mwd = sbit; end
                    OP_MOV:  rn[ctl.dst] = sbit;
                    OP_AND:  rn[ctl.dst] = rq[ctl.dst] & sbit;
                    OP_OR:   rn[ctl.dst] = rq[ctl.dst] | sbit;
                    OP_XOR:  rn[ctl.dst] = rq[ctl.dst] ^ sbit;
                    OP_NOT:  rn[ctl.dst] = ~sbit;
                    OP_ADDM: begin
                        rn[REG_CARRY] = fa[1];
                        rn[ctl.dst]   = fa[0];
                    end
                    OP_ADDMM: begin
                        rn[REG_CARRY] = fa[1];
                        mwe = 1'b1;
                        mwd = fa[0];
                    end
                    OP_SHE:  rn[ctl.dst] = from_w;
                    OP_SHW:  rn[ctl.dst] = from_e;
                    OP_SHN:  rn[ctl.dst] = from_s;
                    OP_SHS:  rn[ctl.dst] = from_n;
                    OP_CLRC: rn[REG_CARRY] = 1'b0;
                    default: ;
                endcase
            end
        end
        if (dep_en) begin
            rn[REG_WORK] = dep_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq <= 4'b1000;
            mq <= '0;
        end else begin
            rq <= rn;
            if (mwe) begin
                mq[addr] <= mwd;
            end
        end
    end

    assign sel_bit  = sbit;
    assign work_bit = rq[REG_WORK];
    assign flag_bit = rq[REG_FLAG];

endmodule

// File: rtl/bsimd_edge.sv
module bsimd_edge
    import bsimd_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  edge_cmd_e       cmd,
    input  logic            axis,
    input  logic [IW-1:0]   idx,
    input  logic [N-1:0]    wdata,
    input  logic [N*N-1:0]  work_grid,
    output logic [N-1:0]    edge_q,
    output logic [N*N-1:0]  dep_en,
    output logic [N*N-1:0]  dep_bits
);

    logic [N-1:0] cap_v;
    logic         hit_v;

    always_comb begin
        cap_v    = '0;
        dep_en   = '0;
        dep_bits = '0;
        hit_v    = 1'b0;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                hit_v = axis ? (idx == IW'(c)) : (idx == IW'(r));
                dep_en[r*N+c] = hit_v && (cmd == EDGE_DEPOSIT);
                if (axis) begin
                    dep_bits[r*N+c] = wdata[r];
                    if (hit_v) cap_v[r] = work_grid[r*N+c];
                end else begin
                    dep_bits[r*N+c] = wdata[c];
                    if (hit_v) cap_v[c] = work_grid[r*N+c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
        end else if (cmd == EDGE_CAPTURE) begin
            edge_q <= cap_v;
        end
    end

endmodule

// File: rtl/bsimd_popcnt.sv
module bsimd_popcnt #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits[i]);
        end
    end

endmodule

// File: rtl/bsimd_cluster.sv
module bsimd_cluster
    import bsimd_pkg::*;
#(
    parameter  int N     = 4,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int IW    = $clog2(N),
    localparam int CELLS = N * N,
    localparam int CW    = $clog2(CELLS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins_valid,
    input  logic [3:0]    ins_op,
    input  logic [1:0]    ins_src,
    input  logic [1:0]    ins_dst,
    input  logic [AW-1:0] ins_addr,
    input  logic          ins_two,
    input  logic [1:0]    edge_cmd,
    input  logic          edge_axis,
    input  logic [IW-1:0] edge_idx,
    input  logic [N-1:0]  edge_wdata,
    output logic          busy,
    output logic [N-1:0]  edge_q,
    output logic [CW-1:0] resp_count
);

    pe_ctl_t          ctl;
    logic [AW-1:0]    ctl_addr;
    logic [CELLS-1:0] sel_bits, work_bits, flag_bits, dep_en, dep_bits;

    bsimd_issue #(.AW(AW)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .ins_valid (ins_valid),
        .ins_op    (pe_op_e'(ins_op)),
        .ins_src   (ins_src),
        .ins_dst   (ins_dst),
        .ins_addr  (ins_addr),
        .ins_two   (ins_two),
        .ctl       (ctl),
        .ctl_addr  (ctl_addr),
        .busy      (busy)
    );

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam int K  = r * N + c;
            localparam int KN = (r > 0)     ? K - N : K;
            localparam int KS = (r < N - 1) ? K + N : K;
            localparam int KW = (c > 0)     ? K - 1 : K;
            localparam int KE = (c < N - 1) ? K + 1 : K;
            logic nb_n, nb_s, nb_e, nb_w;

            assign nb_n = (r > 0)     ? sel_bits[KN] : 1'b0;
            assign nb_s = (r < N - 1) ? sel_bits[KS] : 1'b0;
            assign nb_w = (c > 0)     ? sel_bits[KW] : 1'b0;
            assign nb_e = (c < N - 1) ? sel_bits[KE] : 1'b0;

            bsimd_pe #(.DEPTH(DEPTH), .AW(AW)) u_pe (
                .clk      (clk),
                .rst      (rst),
                .ctl      (ctl),
                .addr     (ctl_addr),
                .from_n   (nb_n),
                .from_s   (nb_s),
                .from_e   (nb_e),
                .from_w   (nb_w),
                .dep_en   (dep_en[K]),
                .dep_bit  (dep_bits[K]),
                .sel_bit  (sel_bits[K]),
                .work_bit (work_bits[K]),
                .flag_bit (flag_bits[K])
            );
        end
    end

    bsimd_edge #(.N(N), .IW(IW)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .cmd       (edge_cmd_e'(edge_cmd)),
        .axis      (edge_axis),
        .idx       (edge_idx),
        .wdata     (edge_wdata),
        .work_grid (work_bits),
        .edge_q    (edge_q),
        .dep_en    (dep_en),
        .dep_bits  (dep_bits)
    );

    bsimd_popcnt #(.W(CELLS), .CW(CW)) u_count (
        .bits  (flag_bits),
        .count (resp_count)
    );

endmodule

// File: rtl/bsimd_cluster_chk.sv
module bsimd_cluster_chk #(
    parameter int N  = 4,
    parameter int CW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           ins_valid,
    input logic           ins_two,
    input logic           busy,
    input logic [1:0]     edge_cmd,
    input logic [N-1:0]   edge_q,
    input logic [CW-1:0]  resp_count,
    input logic [N*N-1:0] flags
);

    a_r3_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (!busy && ins_valid && ins_two) |=> busy);

    a_r3_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(ins_valid && ins_two)) |=> !busy);

    a_r6_edge_hold: assert property (@(posedge clk) disable iff (rst)
        (edge_cmd != 2'd1) |=> $stable(edge_q));

    a_r8_count_match: assert property (@(posedge clk) disable iff (rst)
        (32'(resp_count) == $countones(flags)));

    a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && resp_count == '0 && edge_q == '0));

endmodule

bind bsimd_cluster bsimd_cluster_chk #(.N(N), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ins_valid  (ins_valid),
    .ins_two    (ins_two),
    .busy       (busy),
    .edge_cmd   (edge_cmd),
    .edge_q     (edge_q),
    .resp_count (resp_count),
    .flags      (flag_bits)
);

// File: tb/bsimd_cluster_test.sv
module bsimd_cluster_test;

    localparam int N     = 4;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int IW    = 2;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ins_valid = 1'b0;
    logic [3:0]    ins_op = '0;
    logic [1:0]    ins_src = '0, ins_dst = '0;
    logic [AW-1:0] ins_addr = '0;
    logic          ins_two = 1'b0;
    logic [1:0]    edge_cmd = '0;
    logic          edge_axis = 1'b0;
    logic [IW-1:0] edge_idx = '0;
    logic [N-1:0]  edge_wdata = '0;
    logic          busy;
    logic [N-1:0]  edge_q;
    logic [CW-1:0] resp_count;

    always #2 clk = ~clk;

    bsimd_cluster #(.N(N), .DEPTH(DEPTH)) uut (.*);

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string tag = "R9 reset";

    // behavioural model
    bit       mr[N][N][4];
    bit       mm[N][N][DEPTH];
    bit       m_busy;
    bit [N-1:0] m_edge;
    bit [3:0] p_op;
    bit [1:0] p_src, p_dst;
    int       p_addr;

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            bad++;
            $display("FAIL R3 watchdog: actual=%0d cycles expected<200000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(string t, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic int mcount();
        int n = 0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                n += int'(mr[r][c][2]);
        return n;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                mr[r][c] = '{0, 0, 0, 1};
                for (int a = 0; a < DEPTH; a++) mm[r][c][a] = 0;
            end
        m_busy = 0;
        m_edge = '0;
    endtask

    task automatic model_tick();
        bit fire;
        bit [3:0] op;
        bit [1:0] sr, ds;
        int ad;
        bit o[N][N][4];
        bit om[N][N][DEPTH];
        o = mr;
        om = mm;
        fire = 0; op = 0; sr = 0; ds = 0; ad = 0;
        if (m_busy) begin
            fire = 1; op = p_op; sr = p_src; ds = p_dst; ad = p_addr;
            m_busy = 0;
        end else if (ins_valid && ins_two) begin
            p_op = ins_op; p_src = ins_src; p_dst = ins_dst; p_addr = int'(ins_addr);
            m_busy = 1;
        end else begin
            fire = ins_valid; op = ins_op; sr = ins_src; ds = ins_dst; ad = int'(ins_addr);
        end
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                bit s, m, bn, bs, be, bw;
                int tot;
                s = o[r][c][sr];
                m = om[r][c][ad];
                bn = 0; bs = 0; be = 0; bw = 0;
                if (r > 0)     bn = o[r-1][c][sr];
                if (r < N - 1) bs = o[r+1][c][sr];
                if (c > 0)     bw = o[r][c-1][sr];
                if (c < N - 1) be = o[r][c+1][sr];
                tot = int'(m) + int'(s) + int'(o[r][c][0]);
                if (fire) begin
                    if (op == 14) mr[r][c][3] = s;
                    else if (o[r][c][3]) begin
                        case (op)
                            1:  mr[r][c][ds] = m;
                            2:  mm[r][c][ad] = s;
                            3:  mr[r][c][ds] = s;
                            4:  mr[r][c][ds] = o[r][c][ds] & s;
                            5:  mr[r][c][ds] = o[r][c][ds] | s;
                            6:  mr[r][c][ds] = o[r][c][ds] ^ s;
                            7:  mr[r][c][ds] = ~s;
                            8:  begin mr[r][c][0] = tot[1]; mr[r][c][ds] = tot[0]; end
                            9:  begin mr[r][c][0] = tot[1]; mm[r][c][ad] = tot[0]; end
                            10: mr[r][c][ds] = bw;
                            11: mr[r][c][ds] = be;
                            12: mr[r][c][ds] = bs;
                            13: mr[r][c][ds] = bn;
                            15: mr[r][c][0] = 0;
                            default: ;
                        endcase
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (edge_cmd == 2'd1)
                m_edge[i] = edge_axis ? o[i][edge_idx][1] : o[edge_idx][i][1];
            if (edge_cmd == 2'd2) begin
                if (edge_axis) mr[i][edge_idx][1] = edge_wdata[i];
                else           mr[edge_idx][i][1] = edge_wdata[i];
            end
        end
    endtask

    task automatic go();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        check(tag, "busy", int'(busy), int'(m_busy));
        check(tag, "edge_q", int'(edge_q), int'(m_edge));
        check(tag, "resp_count", int'(resp_count), mcount());
        ins_valid = 0; ins_two = 0; edge_cmd = 2'd0;
    endtask

    task automatic set_ins(int op, int src, int dst, int addr, bit two);
        ins_valid = 1; ins_op = 4'(op); ins_src = 2'(src); ins_dst = 2'(dst);
        ins_addr = AW'(addr); ins_two = two;
    endtask

    task automatic set_edge(int cmd, bit axis, int idx, int wdata);
        edge_cmd = 2'(cmd); edge_axis = axis; edge_idx = IW'(idx); edge_wdata = N'(wdata);
    endtask

    task automatic capture(bit axis, int idx);
        set_edge(1, axis, idx, 0);
        go();
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R9: reset state at the ports, then activity bits read back
        check("R9", "busy", int'(busy), 0);
        check("R9", "resp_count", int'(resp_count), 0);
        check("R9", "edge_q", int'(edge_q), 0);
        set_ins(3, 3, 1, 0, 0); go();
        capture(0, 0);
        check("R9 activity", "edge_q", int'(edge_q), 4'hF);

        // R7 deposit a diagonal, R6 capture rows and columns
        tag = "R7 deposit";
        for (int r = 0; r < N; r++) begin set_edge(2, 0, r, 1 << r); go(); end
        tag = "R6 capture";
        capture(1, 2);
        check("R6 column", "edge_q", int'(edge_q), 4'b0100);
        capture(0, 3);
        check("R6 row", "edge_q", int'(edge_q), 4'b1000);

        // R1 store and load
        tag = "R1 memory";
        set_ins(2, 1, 0, 5, 0); go();
        set_edge(2, 0, 0, 4'hF); go();
        set_ins(1, 0, 1, 5, 0); go();
        capture(0, 0);
        check("R1 load", "edge_q", int'(edge_q), 4'b0001);

        // R8 responder count
        tag = "R8 count";
        set_ins(3, 1, 2, 0, 0); go();
        check("R8", "resp_count", int'(resp_count), 4);

        // R4 neighbour shifts
        tag = "R4 shift";
        set_ins(10, 1, 1, 0, 0); go();
        capture(0, 0);
        check("R4 east", "edge_q", int'(edge_q), 4'b0010);
        capture(0, 3);
        check("R4 east boundary", "edge_q", int'(edge_q), 4'b0000);
        set_ins(12, 1, 1, 0, 0); go();
        capture(0, 0);
        check("R4 north", "edge_q", int'(edge_q), 4'b0100);
        set_ins(13, 1, 1, 0, 0); go();
        capture(0, 1);
        check("R4 south", "edge_q", int'(edge_q), 4'b0100);
        set_ins(11, 1, 1, 0, 0); go();
        capture(0, 1);
        check("R4 west", "edge_q", int'(edge_q), 4'b0010);

        // R2 add with carry
        tag = "R2 add";
        set_edge(2, 0, 0, 4'b0011); go();
        set_ins(2, 1, 0, 7, 0); go();
        set_edge(2, 0, 0, 4'b0101); go();
        set_ins(8, 1, 1, 7, 0); go();
        capture(0, 0);
        check("R2 sum", "edge_q", int'(edge_q), 4'b0110);
        set_ins(3, 0, 1, 0, 0); go();
        capture(0, 0);
        check("R2 carry", "edge_q", int'(edge_q), 4'b0001);

        // R3 two-reference add, instruction during busy ignored
        tag = "R3 two-cycle";
        set_ins(9, 1, 0, 7, 1); go();
        check("R3", "busy", int'(busy), 1);
        set_ins(15, 0, 0, 0, 0); go();
        check("R3", "busy", int'(busy), 0);
        set_ins(1, 0, 1, 7, 0); go();
        capture(0, 0);
        check("R3 mem sum", "edge_q", int'(edge_q), 4'b0011);
        set_ins(3, 0, 1, 0, 0); go();
        capture(0, 0);
        check("R3 ignored clear", "edge_q", int'(edge_q), 4'b0001);

        // R5 masking
        tag = "R5 mask";
        set_edge(2, 0, 0, 4'b1010); go();
        set_ins(14, 1, 0, 0, 0); go();
        set_edge(2, 0, 0, 4'b0000); go();
        set_ins(7, 1, 1, 0, 0); go();
        capture(0, 0);
        check("R5 masked", "edge_q", int'(edge_q), 4'b1010);
        for (int r = 0; r < N; r++) begin set_edge(2, 0, r, 4'hF); go(); end
        set_ins(14, 1, 0, 0, 0); go();
        set_ins(7, 1, 1, 0, 0); go();
        capture(0, 0);
        check("R5 reactivated", "edge_q", int'(edge_q), 4'b0000);

        // R7 deposit priority over an instruction
        tag = "R7 priority";
        set_ins(3, 3, 1, 0, 0);
        set_edge(2, 0, 1, 4'b1001); go();
        capture(0, 1);
        check("R7 priority", "edge_q", int'(edge_q), 4'b1001);
        capture(0, 2);
        check("R7 other row", "edge_q", int'(edge_q), 4'b1111);

        // mix of everything against the model: R1 R2 R3 R4 R5 R6 R7 R8
        tag = "R1-mix R2 R3 R4 R5 R6 R7 R8";
        for (int i = 0; i < 2000; i++) begin
            int v;
            v = int'($urandom);
            if (v[0]) set_ins(v[4:1], v[6:5], v[8:7], v[12:9], v[14:13] == 2'b11);
            set_edge(v[16:15], v[17], v[19:18], v[23:20]);
            go();
        end

        summary();
        $finish;
    end

endmodule